// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block holds the current receive descriptor pointer for one priority queue. Descriptors sit in memory as a singly linked list. Each descriptor carries a link word at offset zero that gives the address of the next descriptor. Software loads the pointer while the queue is idle and then starts the queue. The start strobe only counts when this queue's select bit is set in the same cycle.

Once the receive engine has used up the current descriptor, it pulses an advance request. The block reads the link word through a valid/ready read port. If the link word is non-zero, the pointer moves to that address. A zero link word marks the end of the list, and the pointer stays where it is. A later start strobe makes the block read that same link word again, so descriptors that software has appended since then are picked up.

A stop strobe returns the queue to idle and keeps the pointer value.

Top module: `rx_desc_walker`

## Requirements
- R1: An asynchronous hard reset (`rst_n` low) or a synchronous soft reset (`soft_rst` high at a clock edge) clears the pointer to zero and puts the queue in idle (`q_active`, `q_ready`, `q_tail` all 0).
- R2: The three lowest pointer bits always read zero. Values from a software write and from a fetched link word both have bits 2..0 cleared before they are stored.
- R3: A software write while idle loads the pointer. In idle, `ctrl_start` moves the queue to ready (`q_active`=1, `q_ready`=1) on the next edge only if `ctrl_sel` is 1 in the same cycle. A start strobe with `ctrl_sel`=0 does nothing in any state.
- R4: In ready, `adv_req` starts one link read. `rd_req_valid` rises on the next cycle, with `rd_req_addr` equal to the pointer. Both are held unchanged until `rd_req_ready` is high. A response whose bits 31..3 are non-zero is stored as the new pointer, and the queue returns to ready one edge after `rd_rsp_valid`.
- R5: A response whose bits 31..3 are all zero leaves the pointer unchanged and sets `q_tail`. While the queue is in the tail state, `adv_req` is ignored: no read is issued and the pointer does not change.
- R6: In the tail state, a start strobe with `ctrl_sel`=1 reads the link word of the current descriptor again. If the link is now non-zero, the pointer advances and the queue becomes ready. If it is still zero, the queue returns to the tail state.
- R7: A software write while `q_active`=1 leaves the pointer unchanged. It also raises `wr_err` for exactly one cycle, on the edge after the write.
- R8: `ctrl_stop` in ready or tail returns the queue to idle on the next edge and keeps the pointer. No read request is ever issued while the queue is idle.
- R9: At most one link read is outstanding. `rd_req_valid` drops on the cycle after its handshake. `ctrl_stop` during a fetch lets that fetch finish, with a pointer update if the link is non-zero, and then enters idle without issuing a new read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset |
| reg_wr_en | input | 1 | Software write strobe for the pointer |
| reg_wr_data | input | 32 | Software write value |
| ctrl_start | input | 1 | Queue start / re-check strobe |
| ctrl_sel | input | 1 | This queue's select bit, qualifies `ctrl_start` |
| ctrl_stop | input | 1 | Queue stop strobe |
| adv_req | input | 1 | Engine has consumed the current descriptor |
| rd_req_valid | output | 1 | Link read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | 32 | Link read address (current pointer) |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Link word returned from memory |
| ptr_out | output | 32 | Current descriptor pointer |
| q_active | output | 1 | Queue not idle |
| q_ready | output | 1 | Current descriptor available to the engine |
| q_tail | output | 1 | Parked at the end of the list |
| wr_err | output | 1 | Pulse: software write rejected while active |

## Verification
A corrupted state register shows up at the status outputs on the very next cycle. Examples are a stray read while idle, a missing read after an advance, or the tail flag set while the link word is non-zero. Errors on the pointer path are caught at the first read handshake that follows, when the scoreboard compares each issued address with the address the bench predicted from its own memory image. A lost or extra fetch leaves the expected-address queue unbalanced. An advance that is not ignored at the tail issues a read that nothing expects, and the bench reports it as soon as the request is accepted.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_FETCH = 2'd2,
        ST_TAIL  = 2'd3
    } rxdw_state_e;

    typedef struct packed {
        rxdw_state_e state;
        logic        sent;       // link request accepted, awaiting data
        logic        stop_pend;  // stop seen during a fetch
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RESET = '{state: ST_IDLE, sent: 1'b0, stop_pend: 1'b0};

endpackage

// File: rtl/rxdw_ctrl.sv
module rxdw_ctrl
    import rxdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        start_hit,
    input  logic        stop,
    input  logic        adv,
    input  logic        req_ready,
    input  logic        rsp_valid,
    input  logic        rsp_nonnull,
    output rxdw_state_e state,
    output logic        req_valid,
    output logic        link_load
);

    ctrl_regs_t q, d;
    logic       rsp_take;

    always_comb begin
        d         = q;
        link_load = 1'b0;
        req_valid = (q.state == ST_FETCH) && !q.sent;
        rsp_take  = (q.state == ST_FETCH) && q.sent && rsp_valid;

        case (q.state)
            ST_IDLE: begin
                if (start_hit && !stop) d.state = ST_READY;
            end
            ST_READY: begin
                if (stop) begin
                    d.state = ST_IDLE;
                end else if (adv) begin
                    d.state = ST_FETCH;
                    d.sent  = 1'b0;
                end
            end
            ST_TAIL: begin
                if (stop) begin
                    d.state = ST_IDLE;
                end else if (start_hit) begin
                    d.state = ST_FETCH;
                    d.sent  = 1'b0;
                end
            end
            ST_FETCH: begin
                if (stop) d.stop_pend = 1'b1;
                if (req_valid && req_ready) d.sent = 1'b1;
                if (rsp_take) begin
                    link_load   = rsp_nonnull;
                    d.sent      = 1'b0;
                    d.stop_pend = 1'b0;
                    if (q.stop_pend || stop) d.state = ST_IDLE;
                    else if (rsp_nonnull)    d.state = ST_READY;
                    else                     d.state = ST_TAIL;
                end
            end
            default: d = CTRL_RESET;
        endcase

        if (soft_rst) begin
            d         = CTRL_RESET;
            link_load = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTRL_RESET;
        else        q <= d;
    end

    assign state = q.state;

endmodule

// File: rtl/rxdw_ptr.sv
module rxdw_ptr #(
    parameter int AW    = 32,
    parameter int ALIGN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          idle,
    input  logic          link_load,
    input  logic [AW-1:0] link_data,
    output logic [AW-1:0] ptr,
    output logic          wr_err
);

    localparam logic [AW-1:0] KEEP_MASK = {{(AW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          err;
    } ptr_regs_t;

    localparam ptr_regs_t PTR_RESET = '{ptr: '0, err: 1'b0};

    ptr_regs_t q, d;

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (wr_en) begin
            if (idle) d.ptr = wr_data & KEEP_MASK;
            else      d.err = 1'b1;
        end
        if (link_load) d.ptr = link_data & KEEP_MASK;
        if (soft_rst)  d = PTR_RESET;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= PTR_RESET;
        else        q <= d;
    end

    assign ptr    = q.ptr;
    assign wr_err = q.err;

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rxdw_pkg::*;
#(
    parameter int AW    = 32,
    parameter int ALIGN = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          reg_wr_en,
    input  logic [AW-1:0] reg_wr_data,
    input  logic          ctrl_start,
    input  logic          ctrl_sel,
    input  logic          ctrl_stop,
    input  logic          adv_req,
    output logic          rd_req_valid,
    input  logic          rd_req_ready,
    output logic [AW-1:0] rd_req_addr,
    input  logic          rd_rsp_valid,
    input  logic [AW-1:0] rd_rsp_data,
    output logic [AW-1:0] ptr_out,
    output logic          q_active,
    output logic          q_ready,
    output logic          q_tail,
    output logic          wr_err
);

    rxdw_state_e state;
    logic        start_hit;
    logic        link_nonnull;
    logic        link_load;

    assign start_hit    = ctrl_start & ctrl_sel;
    assign link_nonnull = |rd_rsp_data[AW-1:ALIGN];

    rxdw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .start_hit  (start_hit),
        .stop       (ctrl_stop),
        .adv        (adv_req),
        .req_ready  (rd_req_ready),
        .rsp_valid  (rd_rsp_valid),
        .rsp_nonnull(link_nonnull),
        .state      (state),
        .req_valid  (rd_req_valid),
        .link_load  (link_load)
    );

    rxdw_ptr #(.AW(AW), .ALIGN(ALIGN)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .idle     (state == ST_IDLE),
        .link_load(link_load),
        .link_data(rd_rsp_data),
        .ptr      (ptr_out),
        .wr_err   (wr_err)
    );

    assign rd_req_addr = ptr_out;
    assign q_active    = (state != ST_IDLE);
    assign q_ready     = (state == ST_READY);
    assign q_tail      = (state == ST_TAIL);

endmodule

// File: rtl/rxdw_chk.sv
module rxdw_chk #(
    parameter int AW    = 32,
    parameter int ALIGN = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          reg_wr_en,
    input logic          ctrl_stop,
    input logic          adv_req,
    input logic          rd_req_valid,
    input logic          rd_req_ready,
    input logic [AW-1:0] rd_req_addr,
    input logic [AW-1:0] ptr_out,
    input logic          q_active,
    input logic          q_ready,
    input logic          q_tail,
    input logic          wr_err
);

    a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ptr_out == '0) && !q_active);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_out[ALIGN-1:0] == '0);

    a_r4_adv_issues: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready && adv_req && !ctrl_stop && !soft_rst |=> rd_req_valid && (rd_req_addr == $past(ptr_out)));

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready && !soft_rst |=> rd_req_valid && $stable(rd_req_addr));

    a_r5_tail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        q_tail && !soft_rst |=> $stable(ptr_out));

    a_r7_wr_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && (q_ready || q_tail) && !soft_rst |=> $stable(ptr_out));

    a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && q_active && !soft_rst |=> wr_err);

    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (q_ready || q_tail) && ctrl_stop && !soft_rst |=> !q_active && $stable(ptr_out));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q_active |-> !rd_req_valid);

    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && rd_req_ready |=> !rd_req_valid);

endmodule

bind rx_desc_walker rxdw_chk #(.AW(AW), .ALIGN(ALIGN)) u_rxdw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .reg_wr_en   (reg_wr_en),
    .ctrl_stop   (ctrl_stop),
    .adv_req     (adv_req),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_req_addr (rd_req_addr),
    .ptr_out     (ptr_out),
    .q_active    (q_active),
    .q_ready     (q_ready),
    .q_tail      (q_tail),
    .wr_err      (wr_err)
);

// File: tb/tb_rx_desc_walker.sv
module tb_rx_desc_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic        ctrl_start = 1'b0;
    logic        ctrl_sel = 1'b0;
    logic        ctrl_stop = 1'b0;
    logic        adv_req = 1'b0;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b1;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic [31:0] ptr_out;
    logic        q_active, q_ready, q_tail, wr_err;

    int n_cmp = 0;
    int n_bad = 0;
    int stall_cnt = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_q [$];
    bit          done = 1'b0;

    always #4 clk = ~clk;

    rx_desc_walker dut (.*);

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // memory model + scoreboard monitor for read requests
    initial begin
        bit          pend = 1'b0;
        logic [31:0] paddr = '0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (pend) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem.exists(paddr) ? mem[paddr] : 32'h0;
                pend = 1'b0;
            end
            if (rd_req_valid && stall_cnt > 0) begin
                rd_req_ready = 1'b0;
                stall_cnt--;
            end else begin
                rd_req_ready = 1'b1;
            end
            if (rd_req_valid && rd_req_ready) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5/R9 unexpected read: actual %h expected none", rd_req_addr);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    if (rd_req_addr !== e) begin
                        n_bad++;
                        $display("FAIL R4 read address: actual %h expected %h", rd_req_addr, e);
                    end
                end
                pend  = 1'b1;
                paddr = rd_req_addr;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic sw_write(logic [31:0] v);
        tick(); reg_wr_en = 1'b1; reg_wr_data = v;
        tick(); reg_wr_en = 1'b0;
    endtask

    task automatic start(bit sel);
        tick(); ctrl_start = 1'b1; ctrl_sel = sel;
        tick(); ctrl_start = 1'b0; ctrl_sel = 1'b0;
    endtask

    task automatic stop();
        tick(); ctrl_stop = 1'b1;
        tick(); ctrl_stop = 1'b0;
    endtask

    task automatic advance();
        tick(); adv_req = 1'b1;
        tick(); adv_req = 1'b0;
    endtask

    task automatic settle();
        for (int i = 0; i < 40; i++) begin
            if (!(q_active && !q_ready && !q_tail)) break;
            tick();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        mem[32'h1000] = 32'h2000;
        mem[32'h2000] = 32'h3008;
        mem[32'h3008] = 32'h0;
        repeat (3) tick();
        cmp("R1 reset ptr", ptr_out, 32'h0);
        cmp("R1 reset idle", {29'b0, q_active, q_ready, q_tail}, 32'h0);
        rst_n = 1'b1;

        sw_write(32'h0000_1007);
        cmp("R2/R3 idle write masked", ptr_out, 32'h1000);

        start(1'b0);
        cmp("R3 start without select", {31'b0, q_active}, 32'h0);
        start(1'b1);
        cmp("R3 start with select", {30'b0, q_active, q_ready}, 32'h3);

        exp_q.push_back(32'h1000);
        advance();
        cmp("R4 request raised", {31'b0, rd_req_valid}, 32'h1);
        settle();
        cmp("R4 first advance", ptr_out, 32'h2000);
        cmp("R4 ready again", {31'b0, q_ready}, 32'h1);

        exp_q.push_back(32'h2000);
        stall_cnt = 3;
        advance();
        settle();
        cmp("R4 stalled advance", ptr_out, 32'h3008);

        exp_q.push_back(32'h3008);
        advance();
        settle();
        cmp("R5 null link parks", ptr_out, 32'h3008);
        cmp("R5 tail flag", {31'b0, q_tail}, 32'h1);

        advance();
        repeat (3) tick();
        cmp("R5 advance in tail ignored", ptr_out, 32'h3008);
        cmp("R5 still tail", {31'b0, q_tail}, 32'h1);

        tick(); reg_wr_en = 1'b1; reg_wr_data = 32'hABC0;
        tick(); reg_wr_en = 1'b0;
        cmp("R7 err pulse", {31'b0, wr_err}, 32'h1);
        cmp("R7 ptr kept", ptr_out, 32'h3008);
        tick();
        cmp("R7 err one cycle", {31'b0, wr_err}, 32'h0);

        start(1'b0);
        repeat (2) tick();
        cmp("R3 unselected start in tail", {31'b0, q_tail}, 32'h1);

        exp_q.push_back(32'h3008);
        start(1'b1);
        settle();
        cmp("R6 recheck still null", {31'b0, q_tail}, 32'h1);

        mem[32'h3008] = 32'h4013;
        exp_q.push_back(32'h3008);
        start(1'b1);
        settle();
        cmp("R6/R2 recheck advances masked", ptr_out, 32'h4010);
        cmp("R6 ready after recheck", {31'b0, q_ready}, 32'h1);

        stop();
        cmp("R8 stop idle", {31'b0, q_active}, 32'h0);
        cmp("R8 stop keeps ptr", ptr_out, 32'h4010);

        start(1'b1);
        mem[32'h4010] = 32'h5000;
        exp_q.push_back(32'h4010);
        stall_cnt = 3;
        advance();
        tick(); ctrl_stop = 1'b1;
        tick(); ctrl_stop = 1'b0;
        settle();
        repeat (3) tick();
        cmp("R9 stop during fetch completes", ptr_out, 32'h5000);
        cmp("R9 then idle", {31'b0, q_active}, 32'h0);

        tick(); soft_rst = 1'b1;
        tick(); soft_rst = 1'b0;
        cmp("R1 soft reset ptr", ptr_out, 32'h0);
        cmp("R1 soft reset idle", {31'b0, q_active}, 32'h0);

        cmp("R4/R9 all expected reads seen", exp_q.size(), 32'h0);
        done = 1'b1;
        report();
    end

endmodule